// File: doc/BRIEF.md
# Requester Identity Read-Back Responder

This block answers one configuration register whose read data is the identity of whoever reads it. An agent that does not know its own 16-bit requester ID, because it was assigned during enumeration, reads this register and gets the ID back in the low half of a one-doubleword completion. The value is not stored. Every completion carries the requester ID of the access that caused it, so two agents reading the same address get different answers.

Requests arrive already decoded. Each one has a kind, a doubleword register index, a requester ID and a tag. The kind is either a configuration read or write, or a memory read or write that came in through BAR 0/1. The BAR path produces read data only while the `bar_cfg_map` input says that window is mapped onto configuration space. Writes leave nothing behind. A configuration write to the register gets a completion without data. A memory write gets no response.

Completions leave through a one-entry valid/ready output stage. This stage accepts one request per cycle and emits completions in arrival order.

Top module: `rid_capture_responder`

## Requirements
- R1: A configuration read (kind 2'b00) accepted at index `CAP_DW` produces a completion in the next cycle with `cpl_has_data`=1.
- R2: The payload of a data completion is {16'h0000, requester ID of that same read}. Bits 31:16 are always zero.
- R3: A BAR memory read (kind 2'b10) at index `CAP_DW` while `bar_cfg_map`=1 behaves exactly as in R1 and R2.
- R4: A BAR memory read at index `CAP_DW` while `bar_cfg_map`=0 is consumed and produces no completion.
- R5: Every completion carries the tag and the requester ID of the request that caused it.
- R6: A configuration write (kind 2'b01) at index `CAP_DW` produces a completion with `cpl_has_data`=0 and `cpl_data`=0. A later read still returns only its own requester ID.
- R7: A BAR memory write (kind 2'b11) is consumed and produces no completion.
- R8: A request at any index other than `CAP_DW` is consumed and produces no completion.
- R9: `req_ready` equals (!`cpl_valid` || `cpl_ready`). A pending completion holds all its fields stable while `cpl_ready` is low. Completions leave one per cycle, in acceptance order.
- R10: While reset is asserted (`rst_n`=0), `cpl_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_kind | input | 2 | 00 cfg read, 01 cfg write, 10 BAR read, 11 BAR write |
| req_addr | input | ADDR_W | Doubleword register index |
| req_rid | input | 16 | Requester ID of the access |
| req_tag | input | TAG_W | Request tag |
| bar_cfg_map | input | 1 | BAR 0/1 window mapped onto configuration space |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken on this edge when valid |
| cpl_rid | output | 16 | Requester ID to route the completion back to |
| cpl_tag | output | TAG_W | Tag of the originating request |
| cpl_has_data | output | 1 | Completion carries one doubleword of data |
| cpl_data | output | 32 | Completion payload |

## Verification
The bench builds the block with `ADDR_W`=4, `CAP_DW`=4'hB and `TAG_W`=5. The narrow index lets random addresses land on the capture register often, and about half of all requests are steered there on purpose. Hits and near misses therefore both occur thousands of times in a short run. Random toggling of `bar_cfg_map` and `cpl_ready` covers the unmapped-window and stalled-output cases. With only five tag bits, tags repeat, so ordering errors show up as mismatched requester IDs rather than being masked by unique tags.

// File: rtl/rid_capture_responder.sv
module rid_capture_responder #(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 10,
  parameter logic [ADDR_W-1:0] CAP_DW = ADDR_W'(57)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_rid,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              bar_cfg_map,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [15:0]       cpl_rid,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic              cpl_has_data,
  output logic [31:0]       cpl_data
);
  localparam logic [1:0] K_CFG_RD = 2'b00;
  localparam logic [1:0] K_CFG_WR = 2'b01;
  localparam logic [1:0] K_BAR_RD = 2'b10;
  localparam int         PAD_W    = 32 - 16;

  logic hit, want_data, want_cpl, take;

  assign req_ready = !cpl_valid || cpl_ready;
  assign take      = req_valid && req_ready;
  assign hit       = (req_addr == CAP_DW);
  assign want_data = hit && ((req_kind == K_CFG_RD) ||
                             (req_kind == K_BAR_RD && bar_cfg_map));
  assign want_cpl  = want_data || (hit && req_kind == K_CFG_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid    <= 1'b0;
      cpl_rid      <= '0;
      cpl_tag      <= '0;
      cpl_has_data <= 1'b0;
      cpl_data     <= '0;
    end else if (take) begin
      cpl_valid <= want_cpl;
      if (want_cpl) begin
        cpl_rid      <= req_rid;
        cpl_tag      <= req_tag;
        cpl_has_data <= want_data;
        cpl_data     <= want_data ? {{PAD_W{1'b0}}, req_rid} : '0;
      end
    end else if (cpl_ready) begin
      cpl_valid <= 1'b0;
    end
  end
endmodule

module rid_capture_responder_chk #(
  parameter int ADDR_W = 10,
  parameter int TAG_W  = 10,
  parameter logic [ADDR_W-1:0] CAP_DW = ADDR_W'(57)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [15:0]       req_rid,
  input logic [TAG_W-1:0]  req_tag,
  input logic              bar_cfg_map,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic [15:0]       cpl_rid,
  input logic [TAG_W-1:0]  cpl_tag,
  input logic              cpl_has_data,
  input logic [31:0]       cpl_data
);
  logic acc, rd_hit;
  assign acc    = req_valid && req_ready;
  assign rd_hit = acc && req_addr == CAP_DW &&
                  (req_kind == 2'b00 || (req_kind == 2'b10 && bar_cfg_map));

  AST_RD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> cpl_valid && cpl_has_data &&
               cpl_data == {16'h0000, $past(req_rid)}) else $error("rd"); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> cpl_data[31:16] == 16'h0000) else $error("upper"); // R2
  AST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> cpl_rid == $past(req_rid) && cpl_tag == $past(req_tag)) else $error("route"); // R5
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind == 2'b10 && !bar_cfg_map |=> !cpl_valid) else $error("unmapped"); // R4
  AST_CFG_WR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind == 2'b01 && req_addr == CAP_DW |=> cpl_valid && !cpl_has_data && cpl_data == 32'h0) else $error("wr"); // R6
  AST_BAR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_kind == 2'b11 |=> !cpl_valid) else $error("barwr"); // R7
  AST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_addr != CAP_DW |=> !cpl_valid) else $error("miss"); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_data) && $stable(cpl_rid) &&
                                $stable(cpl_tag) && $stable(cpl_has_data)) else $error("hold"); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !cpl_valid && req_ready) else $error("reset"); // R10
endmodule

bind rid_capture_responder rid_capture_responder_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CAP_DW(CAP_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_addr(req_addr), .req_rid(req_rid), .req_tag(req_tag),
  .bar_cfg_map(bar_cfg_map), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
  .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_has_data(cpl_has_data), .cpl_data(cpl_data)
);

// File: tb/rid_capture_responder_test.sv
module rid_capture_responder_test;
  localparam int AW = 4;
  localparam int TW = 5;
  localparam logic [AW-1:0] CAP = 4'hB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, cpl_ready = 1'b0, bar_cfg_map = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_rid = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, cpl_valid, cpl_has_data;
  logic [15:0] cpl_rid;
  logic [TW-1:0] cpl_tag;
  logic [31:0] cpl_data;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  logic ev = 1'b0, ehd = 1'b0;
  logic [15:0] erid = '0;
  logic [TW-1:0] etag = '0;
  logic [31:0] edata = '0;
  string ewhy = "R10";

  always #10 clk = ~clk;

  rid_capture_responder #(.ADDR_W(AW), .TAG_W(TW), .CAP_DW(CAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_rid(req_rid), .req_tag(req_tag),
    .bar_cfg_map(bar_cfg_map), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_rid(cpl_rid), .cpl_tag(cpl_tag), .cpl_has_data(cpl_has_data), .cpl_data(cpl_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_payload(input logic [15:0] rid);
    return {16'h0000, rid};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                      input logic [15:0] rid, input logic [TW-1:0] tg,
                      input logic map, input logic cr);
    logic acc, hit, dat, cpl;
    chk(cpl_valid == ev, {ewhy, " valid"}, 32'(cpl_valid), 32'(ev));
    if (ev) begin
      chk(cpl_has_data == ehd, {ewhy, " has_data"}, 32'(cpl_has_data), 32'(ehd));
      chk(cpl_data == edata, {ewhy, " R2 data"}, cpl_data, edata);
      chk(cpl_rid == erid && cpl_tag == etag, "R5 rid/tag",
          {cpl_rid, 11'h0, cpl_tag}, {erid, 11'h0, etag});
    end
    req_valid = v; req_kind = k; req_addr = a; req_rid = rid; req_tag = tg;
    bar_cfg_map = map; cpl_ready = cr;
    #1;
    chk(req_ready == (!ev || cr), "R9 ready", 32'(req_ready), 32'(!ev || cr));
    acc = v && (!ev || cr);
    hit = (a == CAP);
    dat = hit && (k == 2'b00 || (k == 2'b10 && map));
    cpl = dat || (hit && k == 2'b01);
    if (acc) begin
      ev = cpl;
      if (cpl) begin
        ehd = dat; erid = rid; etag = tg;
        edata = dat ? rd_payload(rid) : 32'h0;
        ewhy = (k == 2'b00) ? "R1" : (k == 2'b10) ? "R3" : "R6";
      end else begin
        ewhy = !hit ? "R8" : (k == 2'b11) ? "R7" : "R4";
      end
    end else if (ev && cr) begin
      ev = 1'b0;
      ewhy = "R9";
    end else if (ev) begin
      ewhy = "R9 hold";
    end
    @(posedge clk);
    @(negedge clk);
    cycles++;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!cpl_valid && req_ready, "R10 reset", {cpl_valid, req_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    step(1, 2'b00, CAP, 16'hA1B2, 5'd3, 0, 1);            // R1
    step(1, 2'b00, CAP, 16'h0102, 5'd4, 0, 1);            // R2 per-access value
    step(1, 2'b01, CAP, 16'hFFFF, 5'd5, 0, 1);            // R6 write
    step(1, 2'b00, CAP, 16'h1234, 5'd6, 0, 1);            // R6 read after write
    step(1, 2'b10, CAP, 16'h7E7E, 5'd7, 1, 1);            // R3
    step(1, 2'b10, CAP, 16'h5555, 5'd8, 0, 1);            // R4
    step(1, 2'b11, CAP, 16'h3333, 5'd9, 1, 1);            // R7
    step(1, 2'b00, CAP ^ 4'h1, 16'h4444, 5'd10, 1, 1);    // R8
    step(1, 2'b00, CAP, 16'hBEEF, 5'd11, 1, 0);           // R9 stall begins
    step(1, 2'b00, CAP, 16'hDEAD, 5'd12, 1, 0);           // R9 blocked
    step(1, 2'b00, CAP, 16'hDEAD, 5'd12, 1, 1);           // R9 drain + accept
    step(0, 2'b00, CAP, 16'h0, 5'd0, 1, 1);
    step(0, 2'b00, CAP, 16'h0, 5'd0, 1, 1);
    for (int i = 0; i < 6000; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 2) ? CAP : AW'($urandom);
      step(($urandom % 5) != 0, 2'($urandom), a, 16'($urandom), TW'($urandom),
           ($urandom % 3) != 0, ($urandom % 10) < 7);
    end
    step(0, 2'b00, CAP, 16'h0, 5'd0, 1, 1);
    step(0, 2'b00, CAP, 16'h0, 5'd0, 1, 1);
    finish_run();
  end
endmodule